// File: doc/BRIEF.md
# Undervoltage Repetition Fail-Safe Counter

This block guards a power-management controller against an endless loop of supply-undervoltage resets. Under heavy dynamic load the supply can keep dipping below its reset threshold, and each dip restarts the system. The block counts these undervoltage events in a row and asks the mode sequencer for fail-safe entry on the fourth one, so the system stops cycling.

Each event comes in on an asynchronous flag. The block synchronizes it and counts it once, on its rising edge. Counting happens only in the init, normal and stop modes. In normal mode the count is frozen while the battery-undervoltage comparator is asserted. There are three ways to clear the count: entry into fail-safe mode, a software clear of the undervoltage status bit, and a soft reset. A sticky undervoltage status bit and a sticky fail-safe-cause bit let software see what happened. All pins are plain control and status levels or pulses. There is no data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `uv_repeat_guard`

## Requirements
- R1: Every detected undervoltage event sets `uv_sts_o`, in any mode. The bit stays set until `uv_clr_i` is high on a clock edge. If an event and `uv_clr_i` fall on the same edge, the bit ends up set.
- R2: `uv_evt_i` passes through two synchronizer flops plus one edge flop. A low-to-high change counts exactly once, however long the input then stays high. Its effect shows three rising clock edges after the input changes.
- R3: Events are counted only when `mode_i` is init (3'd0), normal (3'd1) or stop (3'd2). Events in restart (3'd3) or fail-safe (3'd4) leave the count unchanged.
- R4: In normal mode, while `batt_uv_i` is high, events leave the count unchanged. In init and stop modes, `batt_uv_i` has no effect.
- R5: The event that raises the count from 3 to 4 makes `fs_req_o` high for exactly one cycle. The count saturates at 4, and further events raise no new request until the count is cleared.
- R6: `fs_cause_o` sets one cycle after a fail-safe request and stays set until `cause_clr_i` is high on a clock edge. Clearing `uv_sts_o` does not clear it.
- R7: Any cycle with `mode_i` equal to fail-safe (3'd4) clears the count.
- R8: A high `uv_clr_i` clears the count.
- R9: A high `soft_rst_i` clears the count.
- R10: If a clear source and a counted event fall on the same edge, the count ends up at zero and no request is raised.
- R11: While `rst_n` is low, all three outputs are 0 and the count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode: 0 init, 1 normal, 2 stop, 3 restart, 4 fail-safe |
| batt_uv_i | input | 1 | Battery-undervoltage comparator flag (synchronous) |
| uv_evt_i | input | 1 | Asynchronous supply-undervoltage event flag |
| uv_clr_i | input | 1 | Software clear of the undervoltage status bit (also clears the count) |
| soft_rst_i | input | 1 | Soft-reset pulse, clears the count |
| cause_clr_i | input | 1 | Software clear of the fail-safe-cause bit |
| uv_sts_o | output | 1 | Sticky undervoltage status bit |
| fs_cause_o | output | 1 | Sticky fail-safe-cause bit |
| fs_req_o | output | 1 | One-cycle fail-safe entry request |

## Verification
The count is measured at the ports as the number of separate event pulses needed before `fs_req_o` fires. Four pulses mean the count started at zero. Zero requests mean the count was held or ignored. Isolated pulses are played in each mode and with the battery flag both set and clear, which separates counting modes from ignored modes and frozen normal mode from unfrozen stop mode. A single long-held event followed by short pulses shows whether the block detects edges or levels. Clear sources are applied both between events and on the very edge of the fourth event, which shows whether clear takes priority over increment.

// File: rtl/uvg_pkg.sv
package uvg_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_INIT     = 3'd0,
    MODE_NORMAL   = 3'd1,
    MODE_STOP     = 3'd2,
    MODE_RESTART  = 3'd3,
    MODE_FAILSAFE = 3'd4
  } op_mode_e;
endpackage

// File: rtl/uvg_edge_sync.sv
// Synchronizes an asynchronous flag and emits one pulse per rising edge.
module uvg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R2: an edge produces a single pulse, never two in a row
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/uvg_sticky.sv
// Sticky flag: set has priority over clear.
module uvg_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R1 / R6: set always lands, even against a clear
  p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R6: without a clear the flag holds
  p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  // R1: the flag never rises without a set
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/uvg_uv_counter.sv
// Consecutive-event counter with mode gating, freeze and clear priority.
module uvg_uv_counter
  import uvg_pkg::*;
#(
  parameter int unsigned LIMIT = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     evt_i,
  input  op_mode_e mode_i,
  input  logic     batt_uv_i,
  input  logic     clr_sw_i,
  input  logic     soft_rst_i,
  output logic     trip_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);
  localparam logic [CW-1:0] CNT_PRE = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          trip_q, trip_d;
  logic          count_en, frozen, clr_any, bump;

  always_comb begin
    count_en = (mode_i == MODE_INIT) || (mode_i == MODE_NORMAL) ||
               (mode_i == MODE_STOP);
    frozen   = (mode_i == MODE_NORMAL) && batt_uv_i;
    clr_any  = clr_sw_i || soft_rst_i || (mode_i == MODE_FAILSAFE);
    bump     = evt_i && count_en && !frozen;
  end

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = 1'b0;
    if (clr_any) begin
      cnt_d = '0;
    end else if (bump && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + 1'b1;
      trip_d = (cnt_q == CNT_PRE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

  assign trip_o = trip_q;

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_trip_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> !trip_q);
  p_trip_at_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |-> (cnt_q == CNT_MAX));
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (cnt_q == '0) && !trip_q);
  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clr_any) |=> $stable(cnt_q));
  p_restart_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_RESTART) && !clr_any) |=> $stable(cnt_q));
  p_failsafe_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FAILSAFE) |=> (cnt_q == '0));
endmodule

// File: rtl/uv_repeat_guard.sv
module uv_repeat_guard
  import uvg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FS_LIMIT    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                batt_uv_i,
  input  logic                uv_evt_i,
  input  logic                uv_clr_i,
  input  logic                soft_rst_i,
  input  logic                cause_clr_i,
  output logic                uv_sts_o,
  output logic                fs_cause_o,
  output logic                fs_req_o
);
  op_mode_e mode;
  logic     uv_rise;
  logic     trip;

  assign mode = op_mode_e'(mode_i);

  uvg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (uv_evt_i),
    .rise_o  (uv_rise)
  );

  uvg_uv_counter #(.LIMIT(FS_LIMIT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (uv_rise),
    .mode_i     (mode),
    .batt_uv_i  (batt_uv_i),
    .clr_sw_i   (uv_clr_i),
    .soft_rst_i (soft_rst_i),
    .trip_o     (trip)
  );

  uvg_sticky u_uv_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (uv_rise),
    .clr_i  (uv_clr_i),
    .flag_o (uv_sts_o)
  );

  uvg_sticky u_fs_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (trip),
    .clr_i  (cause_clr_i),
    .flag_o (fs_cause_o)
  );

  assign fs_req_o = trip;

  // R11: outputs quiet during reset
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r11: assert (!fs_req_o && !uv_sts_o && !fs_cause_o);
    end
  end
endmodule

// File: tb/uv_repeat_guard_tb.sv
`timescale 1ns/1ps
module uv_repeat_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = 3'd1;
  logic       batt_uv_i = 1'b0;
  logic       uv_evt_i = 1'b0;
  logic       uv_clr_i = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       cause_clr_i = 1'b0;
  logic       uv_sts_o, fs_cause_o, fs_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uv_repeat_guard u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .batt_uv_i(batt_uv_i),
    .uv_evt_i(uv_evt_i), .uv_clr_i(uv_clr_i), .soft_rst_i(soft_rst_i),
    .cause_clr_i(cause_clr_i), .uv_sts_o(uv_sts_o),
    .fs_cause_o(fs_cause_o), .fs_req_o(fs_req_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One event pulse; optional clears on the edge that registers it.
  task automatic ev(input logic clr_sw, input logic srst, output logic req);
    @(negedge clk) uv_evt_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    uv_clr_i = clr_sw; soft_rst_i = srst;
    @(negedge clk);
    uv_clr_i = 1'b0; soft_rst_i = 1'b0;
    req = fs_req_o;
    @(negedge clk);
    if (req) chk("R5 request lasts one cycle", fs_req_o, 0);
    uv_evt_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Runs six events; reports the index of the first request (0 if none).
  task automatic expect_n(input string tag, input int exp);
    logic r;
    int first = 0;
    int reqs = 0;
    for (int i = 1; i <= 6; i++) begin
      ev(1'b0, 1'b0, r);
      if (r) begin
        reqs++;
        if (first == 0) first = i;
      end
    end
    chk(tag, first, exp);
    if (exp != 0) chk("R5 saturates, single request", reqs, 1);
  endtask

  task automatic ev_n(input int n);
    logic r;
    for (int i = 0; i < n; i++) ev(1'b0, 1'b0, r);
  endtask

  task automatic clear_all();
    @(negedge clk) uv_clr_i = 1'b1; cause_clr_i = 1'b1;
    @(negedge clk) uv_clr_i = 1'b0; cause_clr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 fs_req in reset", fs_req_o, 0);
    chk("R11 uv_sts in reset", uv_sts_o, 0);
    chk("R11 fs_cause in reset", fs_cause_o, 0);
  endtask

  task automatic t_basic();
    mode_i = 3'd1;
    expect_n("R5 fourth event in normal requests", 4);
    chk("R1 status set by event", uv_sts_o, 1);
    chk("R6 cause set after request", fs_cause_o, 1);
    clear_all();
    chk("R6 cause cleared by cause_clr", fs_cause_o, 0);
    chk("R1 status cleared by uv_clr", uv_sts_o, 0);
  endtask

  task automatic t_failsafe_clear();
    logic r;
    mode_i = 3'd1;
    ev_n(3);
    @(negedge clk) mode_i = 3'd4;
    @(negedge clk) mode_i = 3'd1;
    expect_n("R7 failsafe mode clears count", 4);
    ev(1'b0, 1'b0, r);
    chk("R5 saturated counter gives no request", r, 0);
    @(negedge clk) uv_clr_i = 1'b1;
    @(negedge clk) uv_clr_i = 1'b0;
    chk("R6 cause survives status clear", fs_cause_o, 1);
    clear_all();
  endtask

  task automatic t_held();
    mode_i = 3'd1;
    @(negedge clk) uv_evt_i = 1'b1;
    repeat (20) @(negedge clk);
    uv_evt_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 held event sets status", uv_sts_o, 1);
    expect_n("R2 held high counts once", 3);
    clear_all();
  endtask

  task automatic t_restart();
    mode_i = 3'd3;
    expect_n("R3 restart mode does not count", 0);
    chk("R1 status set in restart mode", uv_sts_o, 1);
    mode_i = 3'd1;
    clear_all();
    @(negedge clk) mode_i = 3'd3;
    ev_n(2);
    @(negedge clk) mode_i = 3'd0;
    expect_n("R3 init mode counts, restart events ignored", 4);
    clear_all();
    mode_i = 3'd1;
  endtask

  task automatic t_freeze();
    mode_i = 3'd1; batt_uv_i = 1'b1;
    expect_n("R4 normal + battery UV freezes", 0);
    batt_uv_i = 1'b0;
    expect_n("R4 normal counts after battery UV drops", 4);
    clear_all();
    mode_i = 3'd2; batt_uv_i = 1'b1;
    expect_n("R4 stop mode ignores battery UV", 4);
    batt_uv_i = 1'b0; mode_i = 3'd1;
    clear_all();
  endtask

  task automatic t_sw_clear();
    mode_i = 3'd1;
    ev_n(3);
    @(negedge clk) uv_clr_i = 1'b1;
    @(negedge clk) uv_clr_i = 1'b0;
    expect_n("R8 uv_clr clears count", 4);
    clear_all();
  endtask

  task automatic t_soft();
    mode_i = 3'd1;
    ev_n(3);
    @(negedge clk) soft_rst_i = 1'b1;
    @(negedge clk) soft_rst_i = 1'b0;
    expect_n("R9 soft reset clears count", 4);
    clear_all();
  endtask

  task automatic t_clear_wins();
    logic r;
    mode_i = 3'd1;
    ev_n(3);
    ev(1'b1, 1'b0, r);
    chk("R10 uv_clr beats fourth event", r, 0);
    chk("R1 set wins over same-edge clear", uv_sts_o, 1);
    expect_n("R10 count zero after uv_clr collision", 4);
    clear_all();
    ev_n(3);
    ev(1'b0, 1'b1, r);
    chk("R10 soft reset beats fourth event", r, 0);
    expect_n("R10 count zero after soft reset collision", 4);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_failsafe_clear();
    t_held();
    t_restart();
    t_freeze();
    t_sw_clear();
    t_soft();
    t_clear_wins();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule